// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a system watchdog that sits on a simple register bus. Software sets a 16-bit timeout, chooses between a reset request and an interrupt as the expiry action, and optionally divides the count clock by a power of two. The state of the enable bit can be set only once after reset. While the watchdog runs, software must service it in time. A service is a write of one key value to the service register, followed directly by a write of a second key value. If no service arrives, the counter reaches the end of its period and the selected expiry action fires.

The bus is single-cycle. A write is accepted when `bus_we` is high at a rising clock edge. Reads are combinational from `bus_addr`. The down-counter reloads itself on expiry, so in interrupt mode the interrupt stays pending, and in reset mode a request pulse repeats every period until software services the watchdog or the system controller acts.

Top module: `wdog_keyed`

## Requirements
- R1: Register map, by byte address: 0x4 is control, with bits 31:16 the timeout, bit 2 enable, bit 1 action select (1 = reset request, 0 = interrupt) and bit 0 prescale select. 0x8 is count, with the running count in bits 15:0 and zero above. Every other address reads zero, including the write-only service address 0xC. After reset, control reads 0xFFFF0000, count reads 0x0000FFFF, and both `rst_req` and `irq` are low.
- R2: A control write takes effect only when all four byte enables are set. If a control write carries a timeout field of zero, the timeout stays unchanged and the write's other fields still apply.
- R3: The first accepted control write after reset fixes the enable bit for good. Later control writes leave enable unchanged, whether it was fixed at 1 or at 0.
- R4: Timeout, action select and prescale select can be rewritten only while the watchdog is disabled. Once enabled, they are locked. While disabled, the count register shows the timeout and does not move. Writes to unmapped addresses change nothing.
- R5: When enabled with timeout T, the count starts at T and falls by one per count tick. A tick is every clock without prescale, or every 2^PRE_W clocks with prescale. Instead of falling from 1 to 0, the count reloads T and signals expiry, so expiry recurs every T ticks.
- R6: In reset mode, each expiry drives `rst_req` high for the one clock that follows it. `irq` is not affected.
- R7: In interrupt mode, an expiry sets `irq`. It stays set until a valid service and never drives `rst_req`.
- R8: A service write goes to address 0xC with byte enables 1:0 set, and its data is in bits 15:0. A service is valid when 0xAA39 is written directly after 0x556C. A valid service reloads the count with T, restarts the prescale divider and clears `irq`. Any other value after 0x556C aborts the sequence, and 0x556C itself re-arms it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_be | input | 4 | Byte enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| rst_req | output | 1 | Reset request pulse on expiry in reset mode |
| irq | output | 1 | Sticky expiry interrupt in interrupt mode |

## Verification
The bench builds the block with PRE_W = 3, so a prescaled tick takes eight clocks instead of 65536. With this setting, every timeout from 1 to 4, both prescale settings and both expiry actions fit in a cycle-by-cycle sweep that spans two full expiry periods. Directed runs cover the write-once enable in both directions, locking of the fields, ignored partial and zero-timeout writes, aborted and restarted key sequences, and restart of the prescale divider by a service.

// File: rtl/wdog_keyed.sv
`timescale 1ns/1ps
module wdog_keyed #(
  parameter int          PRE_W    = 16,
  parameter logic [15:0] TMO_INIT = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  bus_addr,
  input  logic        bus_we,
  input  logic [3:0]  bus_be,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        rst_req,
  output logic        irq
);
  localparam logic [3:0]  A_CTRL = 4'h4;
  localparam logic [3:0]  A_CNT  = 4'h8;
  localparam logic [3:0]  A_SVC  = 4'hC;
  localparam logic [15:0] KEY_A  = 16'h556C;
  localparam logic [15:0] KEY_B  = 16'hAA39;

  logic [15:0]      tmo, cnt;
  logic             en, rsel, psel, en_set, armed;
  logic [PRE_W-1:0] pre;

  wire        ctrl_wr = bus_we && bus_addr == A_CTRL && bus_be == 4'hF;
  wire        svc_wr  = bus_we && bus_addr == A_SVC && bus_be[1:0] == 2'b11;
  wire [15:0] svc_val = bus_wdata[15:0];
  wire        kick    = svc_wr && armed && svc_val == KEY_B;
  wire        fld_wr  = ctrl_wr && !en;
  wire [15:0] tmo_nxt = (fld_wr && bus_wdata[31:16] != 16'd0) ? bus_wdata[31:16] : tmo;
  wire        tick    = !psel || (&pre);
  wire        expire  = en && tick && cnt == 16'd1 && !kick;

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {tmo, 13'd0, en, rsel, psel};
      A_CNT:   bus_rdata = {16'd0, cnt};
      default: bus_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo     <= TMO_INIT;
      cnt     <= TMO_INIT;
      en      <= 1'b0;
      rsel    <= 1'b0;
      psel    <= 1'b0;
      en_set  <= 1'b0;
      armed   <= 1'b0;
      pre     <= '0;
      rst_req <= 1'b0;
      irq     <= 1'b0;
    end else begin
      tmo <= tmo_nxt;
      if (fld_wr) begin
        rsel <= bus_wdata[1];
        psel <= bus_wdata[0];
      end
      if (ctrl_wr && !en_set) begin
        en     <= bus_wdata[2];
        en_set <= 1'b1;
      end
      if (svc_wr) armed <= (svc_val == KEY_A);
      if (!en || kick) pre <= '0;
      else             pre <= pre + 1'b1;
      if (!en || kick || expire) cnt <= tmo_nxt;
      else if (tick)             cnt <= cnt - 16'd1;
      rst_req <= expire && rsel;
      if (kick)                 irq <= 1'b0;
      else if (expire && !rsel) irq <= 1'b1;
    end
  end

  // R3
  en_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_set |=> $stable(en));

  // R4
  fld_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ($stable(tmo) && $stable(rsel) && $stable(psel)));

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt != 16'd0 && cnt <= tmo));

  // R6
  rst_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (rsel && en));

  // R7
  irq_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !rsel);

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !kick) |=> irq);

  // R8
  kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (!irq && cnt == tmo));
endmodule

// File: tb/sim_wdog_keyed.sv
`timescale 1ns/1ps
module sim_wdog_keyed;
  localparam int PW  = 3;
  localparam int DIV = 1 << PW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_be = 4'h0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        rst_req, irq;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  wdog_keyed #(.PRE_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rst_req(rst_req), .irq(irq));

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  // sweep after an enabling write or a valid service; call right after wr returns
  task automatic sweep(input string tag, input int t, input int dv, input bit md,
                       input int kmax, input bit irq0);
    logic [31:0] v;
    for (int k = 0; k <= kmax; k++) begin
      rd(4'h8, v);
      chk({tag, " R5 count"}, v, 32'(t - ((k / dv) % t)));
      chk({tag, " R6 rst_req"}, {31'd0, rst_req},
          {31'd0, md && k > 0 && (k % (t * dv)) == 0});
      chk({tag, " R7 irq"}, {31'd0, irq}, {31'd0, irq0 || (!md && k >= t * dv)});
      @(negedge clk);
    end
  endtask

  initial begin
    logic [31:0] v;
    // R1 reset state
    do_reset();
    rd(4'h4, v); chk("R1 ctrl reset", v, 32'hFFFF0000);
    rd(4'h8, v); chk("R1 count reset", v, 32'h0000FFFF);
    chk("R1 rst_req reset", {31'd0, rst_req}, 32'd0);
    chk("R1 irq reset", {31'd0, irq}, 32'd0);
    for (int a = 0; a < 16; a++) begin
      if (a != 4 && a != 8) begin
        rd(4'(a), v); chk("R1 unmapped read", v, 32'd0);
      end
    end

    // R2 partial write ignored, zero timeout kept
    wr(4'h4, 4'h3, 32'h00050004);
    rd(4'h4, v); chk("R2 partial write", v, 32'hFFFF0000);
    wr(4'h4, 4'hF, 32'h00000002);
    rd(4'h4, v); chk("R2 zero timeout", v, 32'hFFFF0002);
    // R3 enable fixed at 0; R4 fields still writable while disabled
    wr(4'h4, 4'hF, 32'h00050005);
    rd(4'h4, v); chk("R3 R4 disabled rewrite", v, 32'h00050001);
    wr(4'h0, 4'hF, 32'h00070004);
    rd(4'h4, v); chk("R4 unmapped write", v, 32'h00050001);
    repeat (10) @(negedge clk);
    rd(4'h8, v); chk("R4 count idle", v, 32'h00000005);
    chk("R4 rst_req idle", {31'd0, rst_req}, 32'd0);
    chk("R4 irq idle", {31'd0, irq}, 32'd0);

    // R5 R6 R7 sweep over timeout, prescale, action
    for (int t = 1; t <= 4; t++)
      for (int ps = 0; ps < 2; ps++)
        for (int md = 0; md < 2; md++) begin
          int dv;
          dv = ps ? DIV : 1;
          do_reset();
          wr(4'h4, 4'hF, {16'(t), 13'd0, 1'b1, 1'(md), 1'(ps)});
          sweep("sweep", t, dv, 1'(md), 2 * t * dv, 1'b0);
          rd(4'h4, v); chk("R1 ctrl readback", v, {16'(t), 13'd0, 1'b1, 1'(md), 1'(ps)});
        end

    // R3 R4 lock after enable, R8 key sequences
    do_reset();
    wr(4'h4, 4'hF, 32'h00020004);
    repeat (5) @(negedge clk);
    chk("R7 irq set", {31'd0, irq}, 32'd1);
    wr(4'h4, 4'hF, 32'h00090003);
    rd(4'h4, v); chk("R3 R4 locked", v, 32'h00020004);
    wr(4'hC, 4'h3, 32'h0000556C);
    wr(4'hC, 4'h3, 32'h00001234);
    wr(4'hC, 4'h3, 32'h0000AA39);
    chk("R8 aborted sequence", {31'd0, irq}, 32'd1);
    wr(4'hC, 4'h3, 32'h0000AA39);
    chk("R8 lone second key", {31'd0, irq}, 32'd1);
    wr(4'hC, 4'h3, 32'h0000556C);
    wr(4'hC, 4'h3, 32'h0000556C);
    wr(4'hC, 4'h3, 32'h0000AA39);
    sweep("R8 service", 2, 1, 1'b0, 4, 1'b0);

    // R8 service restarts prescaler
    do_reset();
    wr(4'h4, 4'hF, 32'h00030007);
    repeat (5) @(negedge clk);
    wr(4'hC, 4'h3, 32'h0000556C);
    wr(4'hC, 4'h3, 32'h0000AA39);
    sweep("R8 prescale restart", 3, DIV, 1'b1, 3 * DIV * 2, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog timeout");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule